// File: doc/BRIEF.md
# Comma-Detecting 10-Bit Word Aligner

This block sits between a deserializer and an 8b/10b decoder. Its input is a recovered serial stream that has already been cut into 10-bit chunks, with no regard for code-group boundaries. Bit 0 of each chunk is the earliest received bit. The block joins each new chunk to the one before it and searches the combined window at all ten bit offsets for a comma. Both running-disparity forms of the comma are recognised. The block then locks a barrel shift so that each later output word is a whole code group that starts on the comma boundary.

Data moves in and out over valid/ready handshakes. On the input side a chunk is taken on a rising clock edge where `in_valid` and `in_ready` are both high. On the output side a word is delivered on an edge where `out_valid` and `out_ready` are both high. The block never drops a word. While a word waits at the output, the whole two-stage pipeline stops, and `in_ready` stays low until the consumer takes that word. Realignment is controlled by a plain level input, and the lock status is a plain level output.

Top module: `comma_word_aligner`

## Requirements
- R1: While reset is asserted and after it, the block shows `out_valid`=0, `out_comma`=0, `locked`=0 and `in_ready`=1.
- R2: A comma is the 7-bit run 0,0,1,1,1,1,1 or 1,1,0,0,0,0,0 in arrival order. A comma starting at bit offset k (0..9) of the window {current chunk, previous chunk} is detected. The previous chunk occupies window bits 0..9. When a comma sets the offset, the output word for that chunk is window bits k..k+9, with window bit k as output bit 0. The same offset is applied to each later chunk.
- R3: `out_comma` is 1 with a word exactly when a comma begins at the offset applied to that word.
- R4: A chunk accepted at a clock edge appears at the output after the following edge (two cycles of latency) when the output is not stalled.
- R5: `locked` rises together with the output word of the first chunk whose window holds a comma. Only reset clears it.
- R6: While `locked`=1 and `realign_en`=0, a comma at a different offset changes neither the offset nor any later word, and `out_comma`=0 for that word.
- R7: While `realign_en`=1, a comma at a different offset moves the offset to it. That word is then output already realigned, with `out_comma`=1.
- R8: Before the first comma, offset 0 is applied. Each output word is therefore the chunk accepted before the current one, and the first word after reset is all zeros.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0, and `out_data` and `out_comma` keep their values until the word is taken.
- R10: Cycles where `in_valid`=0 do not change the window. Output words follow the accepted chunks in order, one word per chunk, regardless of gaps or stalls.
- R11: When commas appear at several offsets in one window, the lowest offset is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 10 | Unaligned chunk, bit 0 received first |
| in_valid | input | 1 | Chunk on `in_data` is offered |
| in_ready | output | 1 | Block can take a chunk this cycle |
| realign_en | input | 1 | Allow the offset to move after lock |
| out_data | output | 10 | Aligned code group, bit 0 first in time |
| out_valid | output | 1 | Word on `out_data` is offered |
| out_ready | input | 1 | Consumer takes the offered word |
| out_comma | output | 1 | Offered word begins with a comma |
| locked | output | 1 | A comma has been found since reset |

## Verification
The assertions assume that `rst_n` is low at start-up and that `realign_en` is a level sampled on the edge where a word moves to the output. They make no assumption about the pattern on `out_ready`. The stimulus keeps filler bits strictly alternating, and it places each comma so that neither comma form can arise by accident across a chunk seam. As a result, every detection the bench predicts comes only from the code groups it inserted on purpose. Back-pressure runs use a fixed repeating stall pattern, and input gaps fall at fixed chunk positions, so the ordering that the assertions and the checks rely on is seen under both kinds of disturbance.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
  // code-group width and comma run length
  localparam int unsigned CG_W     = 10;
  localparam int unsigned MARK_LEN = 7;
  // vector bit 0 is the earliest bit: 0,0,1,1,1,1,1 and its complement
  localparam logic [MARK_LEN-1:0] MARK_NEG = 7'b1111100;
  localparam logic [MARK_LEN-1:0] MARK_POS = 7'b0000011;
endpackage

// File: rtl/cwa_comma_scan.sv
module cwa_comma_scan #(
  parameter int unsigned GW    = 10,
  parameter int unsigned MLEN  = 7,
  parameter logic [MLEN-1:0] PAT_N = '0,
  parameter logic [MLEN-1:0] PAT_P = '1,
  localparam int unsigned WIN_W = 2*GW - 1
) (
  input  logic [WIN_W-1:0] win,
  output logic [GW-1:0]    hit
);
  // one comparator pair per candidate offset
  for (genvar k = 0; k < GW; k++) begin : g_off
    logic [MLEN-1:0] slice;
    assign slice  = win[k +: MLEN];
    assign hit[k] = (slice == PAT_N) || (slice == PAT_P);
  end
endmodule

// File: rtl/cwa_word_pick.sv
module cwa_word_pick #(
  parameter int unsigned GW = 10,
  localparam int unsigned WIN_W = 2*GW - 1,
  localparam int unsigned OFF_W = $clog2(GW)
) (
  input  logic [WIN_W-1:0] win,
  input  logic [OFF_W-1:0] off,
  output logic [GW-1:0]    word
);
  logic [GW-1:0] cand [GW];

  for (genvar k = 0; k < GW; k++) begin : g_cand
    assign cand[k] = win[k +: GW];
  end

  always_comb begin
    word = cand[0];
    for (int k = 0; k < GW; k++) begin
      if (off == OFF_W'(k)) word = cand[k];
    end
  end
endmodule

// File: rtl/cwa_offset_ctl.sv
module cwa_offset_ctl #(
  parameter int unsigned GW = 10,
  localparam int unsigned OFF_W = $clog2(GW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [GW-1:0]    hits,
  input  logic             realign_en,
  output logic [OFF_W-1:0] off_use,
  output logic             flag,
  output logic             locked
);
  logic [OFF_W-1:0] off_q;
  logic [OFF_W-1:0] first_hit;
  logic             found;
  logic             move;

  // lowest offset wins
  always_comb begin
    first_hit = '0;
    found     = 1'b0;
    for (int k = GW-1; k >= 0; k--) begin
      if (hits[k]) begin
        first_hit = OFF_W'(k);
        found     = 1'b1;
      end
    end
  end

  assign move    = found && (!locked || (realign_en && (first_hit != off_q)));
  assign off_use = move ? first_hit : off_q;

  always_comb begin
    flag = 1'b0;
    for (int k = 0; k < GW; k++) begin
      if (off_use == OFF_W'(k)) flag = hits[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      locked <= 1'b0;
    end else if (step) begin
      if (move)  off_q  <= first_hit;
      if (found) locked <= 1'b1;
    end
  end

  // R5: lock is sticky
  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  // R6: no movement once locked while realignment is off
  a_r6_keep_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !realign_en) |=> $stable(off_q));
  // R2: offset stays within the code group
  a_r2_off_range: assert property (@(posedge clk) disable iff (!rst_n)
    off_q < OFF_W'(GW));
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
  import cwa_pkg::*;
#(
  parameter int unsigned GW   = CG_W,
  parameter int unsigned MLEN = MARK_LEN,
  parameter logic [MLEN-1:0] PAT_N = MARK_NEG,
  parameter logic [MLEN-1:0] PAT_P = MARK_POS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          realign_en,
  output logic [GW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_comma,
  output logic          locked
);
  localparam int unsigned WIN_W = 2*GW - 1;
  localparam int unsigned OFF_W = $clog2(GW);

  logic             adv;
  logic [GW-1:0]    hist_q;
  logic [WIN_W-1:0] win_d, win_q;
  logic [GW-1:0]    hit_d, hit_q;
  logic             s1_valid;
  logic [OFF_W-1:0] off_use;
  logic             flag;
  logic [GW-1:0]    word;

  // whole pipe moves when the output slot is free or being taken
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  assign win_d = {in_data[GW-2:0], hist_q};

  cwa_comma_scan #(.GW(GW), .MLEN(MLEN), .PAT_N(PAT_N), .PAT_P(PAT_P)) u_scan (
    .win (win_d),
    .hit (hit_d)
  );

  // stage 1: window and detections
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q   <= '0;
      win_q    <= '0;
      hit_q    <= '0;
      s1_valid <= 1'b0;
    end else if (adv) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        hist_q <= in_data;
        win_q  <= win_d;
        hit_q  <= hit_d;
      end
    end
  end

  cwa_offset_ctl #(.GW(GW)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (adv && s1_valid),
    .hits       (hit_q),
    .realign_en (realign_en),
    .off_use    (off_use),
    .flag       (flag),
    .locked     (locked)
  );

  cwa_word_pick #(.GW(GW)) u_pick (
    .win  (win_q),
    .off  (off_use),
    .word (word)
  );

  // stage 2: aligned word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_comma <= 1'b0;
    end else if (adv) begin
      out_valid <= s1_valid;
      out_comma <= s1_valid && flag;
      if (s1_valid) out_data <= word;
    end
  end

  // R9: stalled word is held
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_comma)));
  // R9: no intake while the output is stalled
  a_r9_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R3: comma flag only travels with a word
  a_r3_comma_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_comma |-> out_valid);
  // R5: a flagged comma implies lock
  a_r5_comma_locked: assert property (@(posedge clk) disable iff (!rst_n)
    out_comma |-> locked);
endmodule

// File: tb/comma_word_aligner_test.sv
module comma_word_aligner_test;
  localparam int GW  = 10;
  localparam int NCH = 20;
  localparam int NB  = GW*NCH;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [GW-1:0] in_data;
  logic          in_valid, in_ready, realign_en;
  logic [GW-1:0] out_data;
  logic          out_valid, out_ready, out_comma, locked;

  comma_word_aligner uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .realign_en(realign_en), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_comma(out_comma),
    .locked(locked)
  );

  int total = 0;
  int bad   = 0;
  bit sb [NB];
  logic [GW-1:0] exp_word [NCH];
  bit exp_flag [NCH];
  bit exp_lock [NCH];
  int n_got = 0;
  bit mon_on = 0;
  bit stall_mode = 0;
  bit held = 0;
  logic [GW-1:0] held_data;
  int cyc = 0;
  string tag = "";

  task automatic chk(bit ok, string t, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (held) chk(out_valid && out_data == held_data, "R9 held word", out_data, held_data);
      if (out_valid && !out_ready) begin
        chk(in_ready == 1'b0, "R9 in_ready low", in_ready, 0);
        held = 1; held_data = out_data;
      end else held = 0;
      if (out_valid && out_ready) begin
        if (n_got < NCH) begin
          chk(out_data == exp_word[n_got], {tag, " R10 data"}, out_data, exp_word[n_got]);
          chk(out_comma == exp_flag[n_got], {tag, " R3 comma"}, out_comma, exp_flag[n_got]);
          chk(locked == exp_lock[n_got], {tag, " R5 locked"}, locked, exp_lock[n_got]);
        end
        n_got++;
      end
    end
  end

  function automatic bit getb(int i);
    return (i < 0) ? 1'b0 : sb[i];
  endfunction

  task automatic fill();
    for (int i = 0; i < NB; i++) sb[i] = bit'(i % 2);
  endtask

  task automatic put_grp(int p, bit pos);
    bit g [10] = '{0,0,1,1,1,1,1,0,1,0};
    for (int i = 0; i < 10; i++) sb[p+i] = g[i] ^ pos;
  endtask

  // expected stream from the requirements
  task automatic model(bit re, int n);
    int off = 0;
    bit lk = 0;
    for (int j = 0; j < n; j++) begin
      bit hit [GW];
      int lo = -1;
      int base = GW*(j-1);
      for (int k = 0; k < GW; k++) begin
        bit a = 1, b = 1;
        for (int i = 0; i < 7; i++) begin
          bit w = getb(base+k+i);
          bit want = (i >= 2);
          if (w != want) a = 0;
          if (w == want) b = 0;
        end
        hit[k] = a | b;
        if (hit[k] && lo < 0) lo = k;
      end
      if (lo >= 0 && (!lk || (re && lo != off))) off = lo;
      if (lo >= 0) lk = 1;
      exp_flag[j] = hit[off];
      exp_lock[j] = lk;
      for (int i = 0; i < GW; i++) exp_word[j][i] = getb(base+off+i);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    cyc++;
    out_ready = stall_mode ? (cyc % 3 != 1) : 1'b1;
  endtask

  task automatic do_reset();
    mon_on = 0; rst_n = 0; in_valid = 0; in_data = '0;
    out_ready = 1; realign_en = 0; stall_mode = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1; n_got = 0; held = 0;
  endtask

  task automatic drive(bit re, int n, bit gaps, bit stall);
    int guard = 0;
    model(re, n);
    realign_en = re; stall_mode = stall; mon_on = 1;
    for (int j = 0; j < n; j++) begin
      bit acc;
      if (gaps && (j % 4 == 2)) begin in_valid = 0; tick(); end
      for (int i = 0; i < GW; i++) in_data[i] = sb[GW*j+i];
      in_valid = 1;
      forever begin
        @(negedge clk); acc = in_ready;
        tick();
        if (acc) break;
      end
    end
    in_valid = 0; stall_mode = 0; out_ready = 1;
    while (n_got < n && guard < 200) begin tick(); guard++; end
    @(negedge clk);
    chk(n_got == n, {tag, " R10 word count"}, n_got, n);
    mon_on = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; in_valid = 0; out_ready = 1; realign_en = 0;
    repeat (2) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(out_comma == 0, "R1 out_comma", out_comma, 0);
    chk(locked == 0, "R1 locked", locked, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    do_reset();
    @(negedge clk);
    chk(out_valid == 0 && locked == 0, "R1 after release", {out_valid, locked}, 0);
  endtask

  task automatic t_latency();
    do_reset();
    in_data = 10'h2AA; in_valid = 1;
    @(posedge clk); #2 in_valid = 0;
    @(negedge clk);
    chk(out_valid == 0, "R4 not before two cycles", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1, "R4 word after two cycles", out_valid, 1);
    chk(out_data == 0, "R8 first word zero", out_data, 0);
  endtask

  task automatic t_neg();
    do_reset(); fill(); put_grp(23, 0);
    tag = "R2 R8 neg comma"; drive(0, 16, 0, 0);
  endtask

  task automatic t_pos();
    do_reset(); fill(); put_grp(47, 1);
    tag = "R2 pos comma"; drive(0, 16, 0, 0);
  endtask

  task automatic t_hold();
    do_reset(); fill(); put_grp(35, 0); put_grp(102, 0); put_grp(125, 0);
    tag = "R6 hold offset"; drive(0, 16, 0, 0);
  endtask

  task automatic t_realign();
    do_reset(); fill(); put_grp(35, 0); put_grp(102, 0); put_grp(125, 0);
    tag = "R7 realign"; drive(1, 16, 0, 0);
  endtask

  task automatic t_stall();
    do_reset(); fill(); put_grp(35, 0); put_grp(102, 1); put_grp(125, 0);
    tag = "R9 R10 stall gaps"; drive(1, 16, 1, 1);
  endtask

  task automatic t_lowest();
    bit g [12] = '{0,0,1,1,1,1,1,0,0,0,0,0};
    do_reset(); fill();
    for (int i = 0; i < 12; i++) sb[41+i] = g[i];
    tag = "R11 lowest offset"; drive(0, 12, 0, 0);
  endtask

  initial begin
    #(20*150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_neg();
    t_pos();
    t_hold();
    t_realign();
    t_stall();
    t_lowest();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule